// File: doc/BRIEF.md
# Media-Independent Converter Control Register Bank

This block is the register file that configures a five-port media-independent-interface converter. Software reaches it over a plain 32-bit register bus made of an address, a write strobe, write data, a read strobe and read data. It holds several pieces of state:

- a global routing-mode field;
- one control word for each converter port, giving speed, interface type and duplex;
- a per-port enable register that takes ports in and out of reset;
- two 32-bit switch override registers.

The stored values drive the decoded per-port outputs straight away. A port control word, when read, also carries the live RGMII link, duplex and speed status inputs for that port.

The routing-mode register is guarded. It accepts one write only after an exact four-value key has been written to a command address with no other write in between. Any deviation sends the key sequencer back to its start. A mode write that arrives without the key is dropped, and it sets a sticky protection-error output that stays set until reset.

Reads are combinational. While the read strobe is high, the read data reflects the addressed register in the same cycle. While it is low, the read data is zero.

Top module: `mii_conv_regbank`

## Requirements
- R1: After reset the routing mode, every port control word, every port enable, both switch override registers and the protection-error flag are zero, and the key sequencer is at its start.
- R2: Writing 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001 in that order to offset 0x000 arms the lock. The next write to offset 0x020 then loads bits 4:0 into the routing mode, which reads back at 0x020 bits 4:0. Offset 0x000 reads as zero.
- R3: A write to offset 0x000 whose value differs from the next expected key value returns the sequencer to its start. So does a write to any other offset made mid-sequence. A later mode write is then ignored.
- R4: An armed lock allows exactly one mode write and then relocks. A second mode write without a new key sequence is ignored.
- R5: A mode write made while the lock is not armed leaves the routing mode unchanged and sets prot_err_o. Once set, prot_err_o stays 1 until reset.
- R6: The control word of port p sits at offset 0x100 + 4*p for p = 0 to 4. Bits 1:0 hold speed (0 = 10, 1 = 100, 2 = 1000 Mb/s), bits 3:2 hold the interface type (0 = MII, 1 = RMII, 2 = RGMII) and bit 8 selects full duplex. These fields drive the port outputs from the cycle after the write and read back in place.
- R7: In a port control word, bit 12 reads rgmii_link_i[p], bit 13 reads rgmii_fdx_i[p] and bits 15:14 read rgmii_spd_i[2p+1:2p]. Writes to those bits have no effect. All other unlisted bits read zero.
- R8: The enable register at offset 0x114 holds one bit per port in bits 4:0. A 1 marks the port active. The register drives port_en_o and reads back in place.
- R9: The switch speed override register at 0x304 and the switch duplex override register at 0x308 are full 32-bit registers. They drive sw_spd_ovr_o and sw_dpx_ovr_o and read back in place.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register. With the read strobe low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| rgmii_link_i | input | 5 | RGMII link status, one bit per port |
| rgmii_fdx_i | input | 5 | RGMII duplex status, one bit per port |
| rgmii_spd_i | input | 10 | RGMII speed status, two bits per port |
| route_mode_o | output | 5 | Routing-mode field |
| port_speed_o | output | 10 | Speed code, two bits per port |
| port_iftype_o | output | 10 | Interface type code, two bits per port |
| port_fdx_o | output | 5 | Full-duplex select per port |
| port_en_o | output | 5 | Port active (1) or held in reset (0) |
| sw_spd_ovr_o | output | 32 | Switch speed override register |
| sw_dpx_ovr_o | output | 32 | Switch duplex override register |
| prot_err_o | output | 1 | Sticky protection-error flag |

## Verification
The hardest state to reach is an almost-complete key sequence that is broken in the middle. Examples are a wrong value at the third step, a stray write to the enable register between the second and third keys, and a repeated first key. Each must leave the lock unarmed even though the remaining keys then arrive in order. The stimulus sends each of these broken sequences and follows it with a mode write, then checks that the routing mode did not move. It finishes with a clean sequence to show that the sequencer recovered. Relocking is covered by two back-to-back mode writes after a single sequence.

// File: rtl/mii_conv_regbank.sv
module mii_conv_regbank #(
  parameter int NPORT = 5,
  parameter int AW    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_re,
  output logic [31:0]        bus_rdata,
  input  logic [NPORT-1:0]   rgmii_link_i,
  input  logic [NPORT-1:0]   rgmii_fdx_i,
  input  logic [2*NPORT-1:0] rgmii_spd_i,
  output logic [4:0]         route_mode_o,
  output logic [2*NPORT-1:0] port_speed_o,
  output logic [2*NPORT-1:0] port_iftype_o,
  output logic [NPORT-1:0]   port_fdx_o,
  output logic [NPORT-1:0]   port_en_o,
  output logic [31:0]        sw_spd_ovr_o,
  output logic [31:0]        sw_dpx_ovr_o,
  output logic               prot_err_o
);
  localparam logic [AW-1:0] A_CMD   = AW'(32'h000);
  localparam logic [AW-1:0] A_MODE  = AW'(32'h020);
  localparam logic [AW-1:0] A_EN    = AW'(32'h114);
  localparam logic [AW-1:0] A_SWSPD = AW'(32'h304);
  localparam logic [AW-1:0] A_SWDPX = AW'(32'h308);
  localparam int            CONV0   = 32'h100;
  localparam logic [2:0]    ARMED   = 3'd4;

  logic [2:0]  step;
  logic [31:0] key_c;
  logic [31:0] rd;
  wire         armed = (step == ARMED);

  always_comb begin
    case (step)
      3'd0:    key_c = 32'h0000_00A5;
      3'd1:    key_c = 32'h0000_0001;
      3'd2:    key_c = 32'h0000_FFFE;
      3'd3:    key_c = 32'h0000_0001;
      default: key_c = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step         <= '0;
      route_mode_o <= '0;
      prot_err_o   <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_CMD) begin
        step <= (!armed && bus_wdata == key_c) ? step + 3'd1 : 3'd0;
      end else begin
        step <= '0;
        if (bus_addr == A_MODE) begin
          if (armed) route_mode_o <= bus_wdata[4:0];
          else       prot_err_o   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en_o    <= '0;
      sw_spd_ovr_o <= '0;
      sw_dpx_ovr_o <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_EN)    port_en_o    <= bus_wdata[NPORT-1:0];
      if (bus_addr == A_SWSPD) sw_spd_ovr_o <= bus_wdata;
      if (bus_addr == A_SWDPX) sw_dpx_ovr_o <= bus_wdata;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    wire hit = bus_we && (bus_addr == AW'(CONV0 + 4*p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        port_speed_o[2*p +: 2]  <= '0;
        port_iftype_o[2*p +: 2] <= '0;
        port_fdx_o[p]           <= 1'b0;
      end else if (hit) begin
        port_speed_o[2*p +: 2]  <= bus_wdata[1:0];
        port_iftype_o[2*p +: 2] <= bus_wdata[3:2];
        port_fdx_o[p]           <= bus_wdata[8];
      end
    end
  end

  always_comb begin
    rd = '0;
    if (bus_addr == A_MODE)  rd[4:0]       = route_mode_o;
    if (bus_addr == A_EN)    rd[NPORT-1:0] = port_en_o;
    if (bus_addr == A_SWSPD) rd            = sw_spd_ovr_o;
    if (bus_addr == A_SWDPX) rd            = sw_dpx_ovr_o;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == AW'(CONV0 + 4*p)) begin
        rd[1:0]   = port_speed_o[2*p +: 2];
        rd[3:2]   = port_iftype_o[2*p +: 2];
        rd[8]     = port_fdx_o[p];
        rd[12]    = rgmii_link_i[p];
        rd[13]    = rgmii_fdx_i[p];
        rd[15:14] = rgmii_spd_i[2*p +: 2];
      end
    end
  end

  assign bus_rdata = bus_re ? rd : 32'h0;

  p_wrong_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_CMD && bus_wdata != key_c |=> step == 3'd0);

  p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_MODE |=> step == 3'd0);

  p_locked_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_MODE && !armed |=> $stable(route_mode_o) && prot_err_o);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_o |=> prot_err_o);

  p_status_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == AW'(CONV0) |-> bus_rdata[12] == rgmii_link_i[0]);

  p_enable_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_EN |=> port_en_o == $past(bus_wdata[NPORT-1:0]));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == 32'h0);
endmodule

// File: tb/mii_conv_regbank_tb_top.sv
module mii_conv_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [4:0]  rgmii_link_i = '0;
  logic [4:0]  rgmii_fdx_i = '0;
  logic [9:0]  rgmii_spd_i = '0;
  logic [4:0]  route_mode_o;
  logic [9:0]  port_speed_o, port_iftype_o;
  logic [4:0]  port_fdx_o, port_en_o;
  logic [31:0] sw_spd_ovr_o, sw_dpx_ovr_o;
  logic        prot_err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mii_conv_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rgmii_link_i(rgmii_link_i), .rgmii_fdx_i(rgmii_fdx_i), .rgmii_spd_i(rgmii_spd_i),
    .route_mode_o(route_mode_o), .port_speed_o(port_speed_o),
    .port_iftype_o(port_iftype_o), .port_fdx_o(port_fdx_o), .port_en_o(port_en_o),
    .sw_spd_ovr_o(sw_spd_ovr_o), .sw_dpx_ovr_o(sw_dpx_ovr_o), .prot_err_o(prot_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h000, 32'h0000_00A5);
    wr(12'h000, 32'h0000_0001);
    wr(12'h000, 32'h0000_FFFE);
    wr(12'h000, 32'h0000_0001);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 mode", 32'(route_mode_o), 0);
    chk("R1 enable", 32'(port_en_o), 0);
    chk("R1 speed", 32'(port_speed_o), 0);
    chk("R1 iftype/fdx", {port_iftype_o, port_fdx_o}, 0);
    chk("R1 switch regs", sw_spd_ovr_o | sw_dpx_ovr_o, 0);
    chk("R1 prot_err", 32'(prot_err_o), 0);
    rd(12'h100, d); chk("R1 conv0 read", d, 0);
  endtask

  task automatic t_locked_write();
    wr(12'h020, 32'h0000_000A);
    chk("R5 mode unchanged", 32'(route_mode_o), 0);
    chk("R5 prot_err set", 32'(prot_err_o), 1);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    unlock();
    wr(12'h020, 32'hFFFF_FFF3);
    chk("R2 mode loaded", 32'(route_mode_o), 32'h13);
    rd(12'h020, d); chk("R2 mode readback", d, 32'h13);
    rd(12'h000, d); chk("R2 cmd reads zero", d, 0);
    chk("R5 prot_err sticky", 32'(prot_err_o), 1);
  endtask

  task automatic t_relock();
    wr(12'h020, 32'h0000_0005);
    chk("R4 second write ignored", 32'(route_mode_o), 32'h13);
  endtask

  task automatic t_broken();
    wr(12'h000, 32'h0000_00A5); wr(12'h000, 32'h0000_0001);
    wr(12'h000, 32'h0000_FFFF); wr(12'h000, 32'h0000_0001);
    wr(12'h020, 32'h0000_0007);
    chk("R3 wrong key value", 32'(route_mode_o), 32'h13);
    wr(12'h000, 32'h0000_00A5); wr(12'h000, 32'h0000_0001);
    wr(12'h114, 32'h0000_0000);
    wr(12'h000, 32'h0000_FFFE); wr(12'h000, 32'h0000_0001);
    wr(12'h020, 32'h0000_0007);
    chk("R3 foreign write mid-sequence", 32'(route_mode_o), 32'h13);
    wr(12'h000, 32'h0000_00A5); wr(12'h000, 32'h0000_00A5);
    wr(12'h000, 32'h0000_0001); wr(12'h000, 32'h0000_FFFE);
    wr(12'h000, 32'h0000_0001);
    wr(12'h020, 32'h0000_0007);
    chk("R3 repeated first key", 32'(route_mode_o), 32'h13);
    unlock();
    wr(12'h020, 32'h0000_000B);
    chk("R3 recovery after errors", 32'(route_mode_o), 32'h0B);
  endtask

  task automatic t_conv();
    logic [31:0] d;
    wr(12'h108, 32'h0000_010A);
    chk("R6 port2 speed", 32'(port_speed_o), 32'h020);
    chk("R6 port2 iftype", 32'(port_iftype_o), 32'h020);
    chk("R6 port2 fdx", 32'(port_fdx_o), 32'h04);
    rd(12'h108, d); chk("R6 port2 readback", d, 32'h10A);
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h110, d); chk("R6 port4 masked readback", d, 32'h10F);
    chk("R6 port4 speed", 32'(port_speed_o), 32'h320);
  endtask

  task automatic t_status();
    logic [31:0] d;
    rgmii_link_i = 5'b00010; rgmii_fdx_i = 5'b00010; rgmii_spd_i = 10'b00_0000_1000;
    wr(12'h104, 32'h0000_F000);
    rd(12'h104, d); chk("R7 status bits read", d, 32'hB000);
    chk("R7 write to status no effect", {port_speed_o[3:2], port_iftype_o[3:2], 3'b0, port_fdx_o[1]}, 0);
    rgmii_link_i = '0; rgmii_fdx_i = '0; rgmii_spd_i = '0;
    rd(12'h104, d); chk("R7 status follows inputs", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(12'h114, 32'h0000_0015);
    chk("R8 enable out", 32'(port_en_o), 32'h15);
    rd(12'h114, d); chk("R8 enable readback", d, 32'h15);
    wr(12'h114, 32'hFFFF_FFFF);
    rd(12'h114, d); chk("R8 enable masked", d, 32'h1F);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    wr(12'h304, 32'hA5A5_55AA);
    wr(12'h308, 32'h1234_5678);
    chk("R9 speed override out", sw_spd_ovr_o, 32'hA5A5_55AA);
    chk("R9 duplex override out", sw_dpx_ovr_o, 32'h1234_5678);
    rd(12'h308, d); chk("R9 duplex readback", d, 32'h1234_5678);
    wr(12'h304, 0); wr(12'h308, 0);
    rd(12'h304, d); chk("R9 speed cleared", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h200, 32'hDEAD_BEEF);
    wr(12'h30C, 32'hDEAD_BEEF);
    rd(12'h200, d); chk("R10 unmapped read", d, 0);
    rd(12'h010, d); chk("R10 unmapped read 2", d, 0);
    chk("R10 regs untouched", {sw_spd_ovr_o[26:0], port_en_o}, 32'h1F);
    chk("R10 mode untouched", 32'(route_mode_o), 32'h0B);
    @(negedge clk); bus_addr = 12'h114; bus_re = 1'b0;
    #1 chk("R10 no strobe zero", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_write();
    t_unlock();
    t_relock();
    t_broken();
    t_conv();
    t_status();
    t_enable();
    t_switch();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule